// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block turns a conversion request into the ordered list of input selections that a multi-input converter must step through. A request carries a 4-bit channel code, a flag choosing single-ended or pseudo-differential measurement, a 2-bit scan mode and a reference-select bit. The block captures the request and then offers one entry per conversion. Each entry names a positive input and a negative input, and the conversion engine takes entries through a valid/ready handshake. A flag on the final entry marks the end of the sequence.

The block targets a 12-input converter. A parameter shrinks it to 4 or 8 inputs, and the upper channel-code bits that such parts lack are then cleared. In pseudo-differential mode, inputs are paired as neighbours (0,1), (2,3) and so on. The low code bit sets which input of a pair is positive. When the reference-select bit is set, the highest input serves as the external reference. Any selection of that input is then replaced by ground.

Top module: `chan_scan_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid` is 0.
- R2: Scan codes 2'b10 and 2'b11 in single-ended mode (`cfg_single`=1) give one entry, with `out_pos` = channel code and `out_neg` = 4'hF (ground), and `out_last`=1.
- R3: In pseudo-differential mode (`cfg_single`=0), an entry uses the pair {2k, 2k+1}. When the channel code is even, the even input is positive and the odd input is negative. When the code is odd, the two are swapped.
- R4: Scan code 2'b00 in single-ended mode gives entries for channels 0, 1, … up to the code, in ascending order. `out_last` is 1 only on the final entry, and `out_valid` falls after the final entry is accepted.
- R5: Scan code 2'b00 in pseudo-differential mode gives pairs 0 … code/2 in ascending order. Every pair takes the polarity set by bit 0 of the code.
- R6: Scan code 2'b01 gives the entry for the selected code REPEAT times (default 8).
- R7: With 12 inputs, codes 12 to 15 start nothing: `out_valid` stays 0.
- R8: When `cfg_refsel`=1 (and the reference pin is shared), any selection of input NUM_INPUTS-1 is replaced by 4'hF (ground).
- R9: With NUM_INPUTS=4, code bits 3:2 are treated as 0. With NUM_INPUTS=8, bit 3 is treated as 0.
- R10: While `out_valid`=1 and `out_ready`=0, the entry and `out_last` hold. Each accepted transfer advances exactly one entry.
- R11: A `start` pulse while `out_valid`=1 is ignored, and the running sequence goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; captures the cfg_* inputs when idle |
| cfg_sel | input | 4 | Channel code |
| cfg_single | input | 1 | 1 = single-ended, 0 = pseudo-differential |
| cfg_scan | input | 2 | 00 ascending scan, 01 repeat, 10/11 single conversion |
| cfg_refsel | input | 1 | Top input used as reference |
| out_valid | output | 1 | Entry available |
| out_ready | input | 1 | Conversion engine accepts the entry |
| out_pos | output | 4 | Positive input index, 4'hF = ground |
| out_neg | output | 4 | Negative input index, 4'hF = ground |
| out_last | output | 1 | Final entry of the sequence |

## Verification
Directed runs cover the even and odd codes 10 and 11 in an ascending pseudo-differential scan. Together they show that the polarity follows bit 0 across every pair, and is not set once for the first pair only. A single-ended scan up to code 11 with reference-select on shows ground replacing only the top input. A 4-input instance given codes 14 and 7 shows that the code is masked before the scan length and pairing are worked out. Random requests over all modes, with a random stall pattern on `out_ready` and stray start pulses during busy runs, check holding under back-pressure, the placement of the final-entry flag and immunity to restarts. Reserved codes show that no entry is produced.

// File: rtl/chan_scan_pkg.sv
package chan_scan_pkg;
  localparam logic [3:0] GND_CODE = 4'hF;

  typedef enum logic [1:0] {
    SCAN_UP     = 2'b00,
    SCAN_REPEAT = 2'b01,
    SCAN_ONE_A  = 2'b10,
    SCAN_ONE_B  = 2'b11
  } scan_mode_e;

  typedef struct packed {
    logic [3:0] sel;
    logic       single;
    scan_mode_e scan;
    logic       refsel;
  } scan_cfg_t;
endpackage

// File: rtl/chan_cfg_qual.sv
module chan_cfg_qual
  import chan_scan_pkg::*;
#(
  parameter int NUM_INPUTS = 12,
  parameter int REPEAT     = 8,
  parameter int CW         = 4
) (
  input  scan_cfg_t        raw_cfg,
  output scan_cfg_t        q_cfg,
  output logic             reserved,
  output logic [CW-1:0]    count
);
  localparam logic [3:0] SEL_MASK = (NUM_INPUTS <= 4) ? 4'b0011 :
                                    (NUM_INPUTS <= 8) ? 4'b0111 : 4'b1111;

  always_comb begin
    q_cfg     = raw_cfg;
    q_cfg.sel = raw_cfg.sel & SEL_MASK;
    reserved  = (int'(q_cfg.sel) >= NUM_INPUTS);
    unique case (q_cfg.scan)
      SCAN_UP:     count = q_cfg.single ? (CW'(q_cfg.sel) + CW'(1))
                                        : (CW'(q_cfg.sel[3:1]) + CW'(1));
      SCAN_REPEAT: count = CW'(REPEAT);
      default:     count = CW'(1);
    endcase
  end
endmodule

// File: rtl/chan_entry_map.sv
module chan_entry_map
  import chan_scan_pkg::*;
#(
  parameter int NUM_INPUTS = 12,
  parameter bit SHARED_REF = 1'b1,
  parameter int CW         = 4
) (
  input  scan_cfg_t     cfg,
  input  logic [CW-1:0] step,
  output logic [3:0]    pos,
  output logic [3:0]    neg
);
  localparam logic [3:0] TOP = 4'(NUM_INPUTS - 1);

  logic [3:0] s4;
  logic [3:0] ch;
  logic [3:0] pos_raw;
  logic [3:0] neg_raw;

  always_comb begin
    s4 = 4'(step);
    if (cfg.scan == SCAN_UP)
      ch = cfg.single ? s4 : {s4[2:0], cfg.sel[0]};
    else
      ch = cfg.sel;
    pos_raw = ch;
    neg_raw = cfg.single ? GND_CODE : (ch ^ 4'd1);
  end

  generate
    if (SHARED_REF) begin : g_ref
      always_comb begin
        pos = (cfg.refsel && pos_raw == TOP) ? GND_CODE : pos_raw;
        neg = (cfg.refsel && neg_raw == TOP) ? GND_CODE : neg_raw;
      end
    end else begin : g_noref
      always_comb begin
        pos = pos_raw;
        neg = neg_raw;
      end
    end
  endgenerate
endmodule

// File: rtl/chan_step_ctrl.sv
module chan_step_ctrl #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          xfer,
  input  logic [CW-1:0] count_in,
  output logic [CW-1:0] step_next,
  output logic          valid,
  output logic          last
);
  logic [CW-1:0] step_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] count_sel;

  always_comb begin
    count_sel = accept ? count_in : count_q;
    if (accept)
      step_next = '0;
    else if (xfer && !last)
      step_next = step_q + CW'(1);
    else
      step_next = step_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      last    <= 1'b0;
      step_q  <= '0;
      count_q <= '0;
    end else begin
      if (accept) count_q <= count_in;
      step_q <= step_next;
      last   <= (step_next == count_sel - CW'(1));
      if (accept)
        valid <= 1'b1;
      else if (xfer && last)
        valid <= 1'b0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !valid); // R1
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    valid |-> step_q < count_q); // R4
endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
  import chan_scan_pkg::*;
#(
  parameter int NUM_INPUTS = 12,
  parameter int REPEAT     = 8,
  parameter bit SHARED_REF = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [3:0] cfg_sel,
  input  logic       cfg_single,
  input  logic [1:0] cfg_scan,
  input  logic       cfg_refsel,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [3:0] out_pos,
  output logic [3:0] out_neg,
  output logic       out_last
);
  localparam int MAXCNT = (REPEAT > NUM_INPUTS) ? REPEAT : NUM_INPUTS;
  localparam int CW     = $clog2(MAXCNT + 1);
  localparam logic [3:0] TOP = 4'(NUM_INPUTS - 1);

  scan_cfg_t     raw_cfg, in_cfg, cfg_q, cfg_next;
  logic          in_reserved;
  logic [CW-1:0] in_count;
  logic [CW-1:0] step_next;
  logic          accept, xfer;
  logic [3:0]    pos_d, neg_d;

  always_comb begin
    raw_cfg.sel    = cfg_sel;
    raw_cfg.single = cfg_single;
    raw_cfg.scan   = scan_mode_e'(cfg_scan);
    raw_cfg.refsel = cfg_refsel;
  end

  chan_cfg_qual #(.NUM_INPUTS(NUM_INPUTS), .REPEAT(REPEAT), .CW(CW)) u_qual (
    .raw_cfg (raw_cfg),
    .q_cfg   (in_cfg),
    .reserved(in_reserved),
    .count   (in_count)
  );

  assign accept   = start && !out_valid && !in_reserved;
  assign xfer     = out_valid && out_ready;
  assign cfg_next = accept ? in_cfg : cfg_q;

  chan_step_ctrl #(.CW(CW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .xfer     (xfer),
    .count_in (in_count),
    .step_next(step_next),
    .valid    (out_valid),
    .last     (out_last)
  );

  chan_entry_map #(.NUM_INPUTS(NUM_INPUTS), .SHARED_REF(SHARED_REF), .CW(CW)) u_map (
    .cfg (cfg_next),
    .step(step_next),
    .pos (pos_d),
    .neg (neg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      out_pos <= GND_CODE;
      out_neg <= GND_CODE;
    end else if (accept || xfer) begin
      cfg_q   <= cfg_next;
      out_pos <= pos_d;
      out_neg <= neg_d;
    end
  end

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pos) && $stable(out_neg)
                                && $stable(out_last)); // R10
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid); // R4
  AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !cfg_q.single && out_pos != GND_CODE && out_neg != GND_CODE
    |-> (out_pos ^ out_neg) == 4'd1); // R3
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pos == GND_CODE || int'(out_pos) < NUM_INPUTS) &&
                  (out_neg == GND_CODE || int'(out_neg) < NUM_INPUTS)); // R9
  AST_REF_TO_GND: assert property (@(posedge clk) disable iff (rst)
    out_valid && cfg_q.refsel && SHARED_REF |-> out_pos != TOP && out_neg != TOP); // R8
endmodule

// File: tb/test_chan_scan_seq.sv
module test_chan_scan_seq;
  localparam logic [3:0] G = 4'hF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start12 = 1'b0, start4 = 1'b0;
  logic [3:0] sel = '0;
  logic single = 1'b1, refsel = 1'b0, ready = 1'b0;
  logic [1:0] scan = '0;
  logic v12, l12, v4, l4;
  logic [3:0] p12, n12, p4, n4;

  int tests = 0, fails = 0;
  int exp_cnt;
  logic [3:0] exp_p [0:15];
  logic [3:0] exp_n [0:15];

  always #2.5 clk = ~clk;

  chan_scan_seq i_chan_scan_seq (
    .clk(clk), .rst(rst), .start(start12), .cfg_sel(sel), .cfg_single(single),
    .cfg_scan(scan), .cfg_refsel(refsel), .out_valid(v12), .out_ready(ready),
    .out_pos(p12), .out_neg(n12), .out_last(l12));

  chan_scan_seq #(.NUM_INPUTS(4)) i_chan_scan_seq_n4 (
    .clk(clk), .rst(rst), .start(start4), .cfg_sel(sel), .cfg_single(single),
    .cfg_scan(scan), .cfg_refsel(refsel), .out_valid(v4), .out_ready(ready),
    .out_pos(p4), .out_neg(n4), .out_last(l4));

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic void add_entry(int n, int a, int b, bit rs);
    logic [3:0] pa, pb;
    pa = 4'(a); pb = 4'(b);
    if (rs && n != 8) begin
      if (a == n - 1) pa = G;
      if (b == n - 1) pb = G;
    end
    exp_p[exp_cnt] = pa;
    exp_n[exp_cnt] = pb;
    exp_cnt++;
  endfunction

  // Expected sequence built from the requirements
  function automatic void build(int n, int code, bit se, int mode, bit rs);
    int s, a, b;
    exp_cnt = 0;
    s = (n == 4) ? (code & 3) : (n == 8) ? (code & 7) : code;
    if (s >= 12) return;
    if (se) begin a = s; b = 15; end
    else if (s % 2 == 1) begin a = s; b = s - 1; end
    else begin a = s; b = s + 1; end
    if (mode == 0) begin
      if (se) for (int k = 0; k <= s; k++) add_entry(n, k, 15, rs);
      else for (int k = 0; k <= s / 2; k++)
        if (s % 2 == 1) add_entry(n, 2 * k + 1, 2 * k, rs);
        else add_entry(n, 2 * k, 2 * k + 1, rs);
    end else if (mode == 1) begin
      for (int k = 0; k < 8; k++) add_entry(n, a, b, rs);
    end else add_entry(n, a, b, rs);
  endfunction

  task automatic run_seq(input int n, input int code, input bit se, input int mode,
                         input bit rs, input bit poke, input string tag);
    int idx, guard;
    bit hold_pend;
    logic [3:0] hp, hn;
    logic hl;
    logic v, l;
    logic [3:0] p, q;
    build(n, code, se, mode, rs);
    @(negedge clk);
    sel = 4'(code); single = se; scan = 2'(mode); refsel = rs;
    if (n == 4) start4 = 1'b1; else start12 = 1'b1;
    @(negedge clk);
    start4 = 1'b0; start12 = 1'b0;
    idx = 0; guard = 0; hold_pend = 0;
    while (idx < exp_cnt && guard < 400) begin
      if (guard > 0) @(negedge clk);
      guard++;
      if (start12 || start4) begin start12 = 1'b0; start4 = 1'b0; end
      ready = ($urandom % 3) != 0;
      v = (n == 4) ? v4 : v12; l = (n == 4) ? l4 : l12;
      p = (n == 4) ? p4 : p12; q = (n == 4) ? n4 : n12;
      if (hold_pend) begin
        check(v && p == hp && q == hn && l == hl, "R10 hold", int'(p), int'(hp));
        hold_pend = 0;
      end
      if (poke && idx == 1) begin
        // R11: stray start while busy with other settings
        sel = 4'($urandom % 12); single = ~se; scan = 2'($urandom % 4);
        if (n == 4) start4 = 1'b1; else start12 = 1'b1;
      end
      if (v && ready) begin
        check(p == exp_p[idx] && q == exp_n[idx], {tag, " entry"},
              int'({p, q}), int'({exp_p[idx], exp_n[idx]}));
        check(l == (idx == exp_cnt - 1), {tag, " last flag"}, int'(l),
              int'(idx == exp_cnt - 1));
        idx++;
      end else if (v) begin
        hold_pend = 1; hp = p; hn = q; hl = l;
      end
    end
    @(negedge clk);
    start12 = 1'b0; start4 = 1'b0;
    ready = 1'b0;
    v = (n == 4) ? v4 : v12;
    check(idx == exp_cnt && !v, {tag, poke ? " R11 end" : " R4 end"}, idx, exp_cnt);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!v12 && !v4, "R1 reset", int'(v12), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!v12 && !v4, "R1 after reset", int'(v12), 0);

    run_seq(12, 5, 1, 2, 0, 0, "R2");
    run_seq(12, 3, 1, 3, 0, 0, "R2");
    run_seq(12, 6, 0, 2, 0, 0, "R3 even");
    run_seq(12, 7, 0, 3, 0, 0, "R3 odd");
    run_seq(12, 11, 1, 0, 0, 0, "R4");
    run_seq(12, 0, 1, 0, 0, 0, "R4 min");
    run_seq(12, 10, 0, 0, 0, 0, "R5 even");
    run_seq(12, 11, 0, 0, 0, 0, "R5 odd");
    run_seq(12, 4, 0, 1, 0, 0, "R6");
    run_seq(12, 11, 1, 0, 1, 0, "R8 se");
    run_seq(12, 10, 0, 0, 1, 0, "R8 pd");
    run_seq(4, 14, 1, 0, 0, 0, "R9 n4");
    run_seq(4, 7, 0, 0, 1, 0, "R9 n4 ref");
    run_seq(12, 9, 1, 0, 0, 1, "R11");

    for (int c = 12; c < 16; c++) begin
      @(negedge clk);
      sel = 4'(c); single = c[0]; scan = 2'(c % 4);
      start12 = 1'b1;
      @(negedge clk);
      start12 = 1'b0;
      repeat (2) begin
        check(!v12, "R7 reserved", int'(v12), 0);
        @(negedge clk);
      end
    end

    for (int t = 0; t < 40; t++) begin
      int nn;
      nn = ($urandom % 4 == 0) ? 4 : 12;
      run_seq(nn, int'($urandom % 12), 1'($urandom), int'($urandom % 4),
              1'($urandom), 1'($urandom % 5 == 0), "R10 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule